// File: doc/BRIEF.md
# QoS Settings Command Port

This block holds the quality-of-service settings of every channel of an interconnect and lets software reach them through a two-word mailbox instead of a directly mapped register per setting. Software loads an operand word, then writes a command word that names a channel, a setting kind and a direction, with a start flag set. One cycle later the access runs against the settings table. On a store, the selected field of the operand word goes into the table. On a fetch, the stored value comes back into the operand word at the same field position. The start flag then drops, and software polls for that.

The table holds `NUM_CH` channels, 30 by default. Each master has two channels: an even index for its read channel and the next odd index for its write channel. Each entry holds a peak rate and a transaction rate of 12 bits each, an 8-bit burstiness value, a 4-bit QoS level and a slave-ready enable. Every stored value is presented as flat vectors to the traffic regulators, which are outside this block. A read-only version word and a hardware-configuration word complete the register set. A soft reset returns the whole table to its defaults.

Top module: `qos_cfg_port`

## Requirements
- R1: After `rst_n` is low at a clock edge, the command word (index 2) and the operand word (index 3) read 0. Every channel is at its default: both rates 0, burstiness 0, QoS 0, slave-ready 1.
- R2: A host write to the command word with bit 31 = 1 and bit 29 = 0 makes bit 31 read 1 after that edge. Bit 31 reads 0 after the following edge, and that is the edge where the access takes effect.
- R3: A store with code 1 (bit 30 = 1 means store, bits 2:0 hold the code, bits 11:7 the channel) copies operand bits 31:20 to the channel's peak rate and bits 15:4 to its transaction rate.
- R4: Store codes 0, 2 and 3 each change one field of the selected channel. Code 0 copies operand bits 23:16 to burstiness, code 2 copies bits 3:0 to QoS, and code 3 copies bit 0 to slave-ready. No other channel or field changes.
- R5: A fetch (bit 30 = 0) with a valid channel and code loads the operand word with the selected value at the position used by R3 and R4, and all other bits 0.
- R6: A channel index of `NUM_CH` or more, or a code of 4 to 7, sets the error flag (bit 28). The table and the operand word stay unchanged, and bit 31 still clears.
- R7: The error flag stays set until a command-word write carries 0 in bit 28. A write carrying 1 in bit 28 leaves it as it is.
- R8: A command-word write with bit 29 = 1 makes bit 29 read 1 for one cycle. At the next edge every channel returns to its default and bit 29 reads 0. Bit 31 is not set by such a write.
- R9: A command-word write that arrives while bit 31 reads 1 is ignored: the pending access runs with its own channel, code and direction.
- R10: The version word (index 0) reads `VERSION_ID` and the configuration word (index 1) reads `{16'b0, 8'd4, 8'(NUM_CH)}`. Host writes change neither.
- R11: The command word reads back as `{start, dir, soft_reset, error, 16'b0, channel, 4'b0, code}`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | 2 | Word index: 0 version, 1 configuration, 2 command, 3 operand |
| host_wr | input | 1 | Host write strobe, one cycle per write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Read data of the word at `host_addr`, combinational |
| peak_rate_o | output | NUM_CH*12 | Peak rate of channel i at bits i*12 +: 12 |
| xact_rate_o | output | NUM_CH*12 | Transaction rate of channel i at bits i*12 +: 12 |
| burst_o | output | NUM_CH*8 | Burstiness of channel i at bits i*8 +: 8 |
| qos_o | output | NUM_CH*4 | QoS level of channel i at bits i*4 +: 4 |
| sready_o | output | NUM_CH | Slave-ready enable of channel i at bit i |

## Verification
A command written at edge T shows the start flag from T onward. The table outputs, the operand word and the error flag change at edge T+1, when the start flag drops. A soft reset shows bit 29 for one cycle, and the defaults appear at the edge after that. The bench drives each write on a falling edge so that the next rising edge captures it. It then checks the start flag half a cycle after T and checks the results half a cycle after T+1. At that point it compares every channel of the table against its own model, and also checks the command readback. The sweeps cover all 32 channel indices with all 8 codes, first as stores and then as fetches.

// File: rtl/qos_cfg_pkg.sv
// Package: shared constants, register indices, command codes and the
// per-channel settings entry for the QoS settings command port.
// Assumes a 32-bit host word. Field positions are fixed by the word format.
package qos_cfg_pkg;

    localparam int WORD_W     = 32;
    localparam int CH_FIELD_W = 5;
    localparam int CODE_W     = 3;
    localparam int RATE_W     = 12;
    localparam int BURST_W    = 8;
    localparam int QOS_W      = 4;
    localparam int NUM_CODES  = 4;

    // Command word bit positions
    localparam int BIT_START  = 31;
    localparam int BIT_DIR    = 30;
    localparam int BIT_SRST   = 29;
    localparam int BIT_ERR    = 28;
    localparam int CH_LSB     = 7;
    localparam int CODE_LSB   = 0;

    // Operand word field positions
    localparam int PEAK_LSB   = 20;
    localparam int XACT_LSB   = 4;
    localparam int BURST_LSB  = 16;
    localparam int QOS_LSB    = 0;
    localparam int SRDY_LSB   = 0;

    typedef enum logic [1:0] {
        REG_VERSION = 2'd0,
        REG_HWCFG   = 2'd1,
        REG_CMD     = 2'd2,
        REG_DATA    = 2'd3
    } reg_sel_e;

    typedef enum logic [CODE_W-1:0] {
        CODE_BURST  = 3'd0,
        CODE_RATE   = 3'd1,
        CODE_QOS    = 3'd2,
        CODE_SREADY = 3'd3
    } cmd_code_e;

    typedef struct packed {
        logic [RATE_W-1:0]  peak;
        logic [RATE_W-1:0]  xact;
        logic [BURST_W-1:0] burst;
        logic [QOS_W-1:0]   qos;
        logic               sready;
    } qos_entry_t;

    localparam qos_entry_t ENTRY_DEFAULT = '{
        peak: '0, xact: '0, burst: '0, qos: '0, sready: 1'b1
    };

    // Place one stored setting at its operand-word position, the rest zero
    function automatic logic [WORD_W-1:0] pack_field(
        input logic [CODE_W-1:0] code,
        input qos_entry_t        e
    );
        logic [WORD_W-1:0] w;
        w = '0;
        case (code)
            CODE_BURST:  w[BURST_LSB +: BURST_W] = e.burst;
            CODE_RATE: begin
                w[PEAK_LSB +: RATE_W] = e.peak;
                w[XACT_LSB +: RATE_W] = e.xact;
            end
            CODE_QOS:    w[QOS_LSB +: QOS_W] = e.qos;
            CODE_SREADY: w[SRDY_LSB] = e.sready;
            default:     w = '0;
        endcase
        return w;
    endfunction

endpackage

// File: rtl/qos_cmd_decode.sv
// Module: qos_cmd_decode
// Checks a pending command for a legal channel index and code, and turns a
// legal store into a one-hot field write enable indexed by the code.
// Assumes NUM_CH <= 32 and that go is high for exactly the execution cycle.
module qos_cmd_decode
    import qos_cfg_pkg::*;
#(
    parameter int NUM_CH = 30
) (
    input  logic                  go,
    input  logic                  dir_store,
    input  logic [CH_FIELD_W-1:0] ch,
    input  logic [CODE_W-1:0]     code,
    output logic                  bad,
    output logic [NUM_CODES-1:0]  field_we
);

    localparam int CODE_SEL_W = $clog2(NUM_CODES);

    logic ch_ok;
    logic code_ok;

    // Legality of the command and the one-hot store enable
    always_comb begin
        ch_ok    = int'(ch) < NUM_CH;
        code_ok  = int'(code) < NUM_CODES;
        bad      = !(ch_ok && code_ok);
        field_we = '0;
        if (go && dir_store && !bad) begin
            field_we[code[CODE_SEL_W-1:0]] = 1'b1;
        end
    end

endmodule

// File: rtl/qos_setting_table.sv
// Module: qos_setting_table
// Per-channel settings storage. One entry per channel, each written field by
// field. A soft clear or reset restores the defaults. Presents every entry as
// flat vectors and the selected entry for fetches.
// Assumes field_we is one-hot or zero and indexed by command code.
module qos_setting_table
    import qos_cfg_pkg::*;
#(
    parameter int NUM_CH = 30
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       soft_clr,
    input  logic [CH_FIELD_W-1:0]      sel_ch,
    input  logic [NUM_CODES-1:0]       field_we,
    input  logic [WORD_W-1:0]          wdata,
    output qos_entry_t                 sel_entry,
    output logic [NUM_CH*RATE_W-1:0]   peak_flat,
    output logic [NUM_CH*RATE_W-1:0]   xact_flat,
    output logic [NUM_CH*BURST_W-1:0]  burst_flat,
    output logic [NUM_CH*QOS_W-1:0]    qos_flat,
    output logic [NUM_CH-1:0]          sready_flat
);

    qos_entry_t ent_all [NUM_CH];

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        qos_entry_t ent_q;
        logic       hit;

        assign hit = (sel_ch == CH_FIELD_W'(g));

        // Hold one channel's settings and apply its field writes
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_q <= ENTRY_DEFAULT;
            end else if (soft_clr) begin
                ent_q <= ENTRY_DEFAULT;
            end else if (hit) begin
                if (field_we[CODE_BURST]) begin
                    ent_q.burst <= wdata[BURST_LSB +: BURST_W];
                end
                if (field_we[CODE_RATE]) begin
                    ent_q.peak <= wdata[PEAK_LSB +: RATE_W];
                    ent_q.xact <= wdata[XACT_LSB +: RATE_W];
                end
                if (field_we[CODE_QOS]) begin
                    ent_q.qos <= wdata[QOS_LSB +: QOS_W];
                end
                if (field_we[CODE_SREADY]) begin
                    ent_q.sready <= wdata[SRDY_LSB];
                end
            end
        end

        assign ent_all[g]                        = ent_q;
        assign peak_flat[g*RATE_W +: RATE_W]     = ent_q.peak;
        assign xact_flat[g*RATE_W +: RATE_W]     = ent_q.xact;
        assign burst_flat[g*BURST_W +: BURST_W]  = ent_q.burst;
        assign qos_flat[g*QOS_W +: QOS_W]        = ent_q.qos;
        assign sready_flat[g]                    = ent_q.sready;
    end

    // Select the addressed entry for a fetch; out-of-range gives the default
    always_comb begin
        sel_entry = ENTRY_DEFAULT;
        for (int i = 0; i < NUM_CH; i++) begin
            if (sel_ch == CH_FIELD_W'(i)) begin
                sel_entry = ent_all[i];
            end
        end
    end

endmodule

// File: rtl/qos_cfg_port.sv
// Module: qos_cfg_port
// Host-facing mailbox for the per-channel QoS settings: four 32-bit words
// (version, configuration, command, operand). A command with the start flag
// set runs one table access on the next cycle and then clears the flag.
// Assumes one host write per cycle, reads combinational, NUM_CH <= 32.
module qos_cfg_port
    import qos_cfg_pkg::*;
#(
    parameter int          NUM_CH     = 30,
    parameter logic [31:0] VERSION_ID = 32'h0102_0000
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [1:0]                 host_addr,
    input  logic                       host_wr,
    input  logic [31:0]                host_wdata,
    output logic [31:0]                host_rdata,
    output logic [NUM_CH*RATE_W-1:0]   peak_rate_o,
    output logic [NUM_CH*RATE_W-1:0]   xact_rate_o,
    output logic [NUM_CH*BURST_W-1:0]  burst_o,
    output logic [NUM_CH*QOS_W-1:0]    qos_o,
    output logic [NUM_CH-1:0]          sready_o
);

    localparam logic [31:0] HWCFG_WORD = {16'b0, 8'(NUM_CODES), 8'(NUM_CH)};

    logic                  cmd_en;
    logic                  cmd_dir;
    logic                  cmd_swrst;
    logic                  cmd_err;
    logic [CH_FIELD_W-1:0] cmd_ch;
    logic [CODE_W-1:0]     cmd_code;
    logic [WORD_W-1:0]     data_q;

    logic                  cmd_wr;
    logic                  data_wr;
    logic                  bad;
    logic [NUM_CODES-1:0]  field_we;
    qos_entry_t            sel_entry;
    logic                  fetch_done;
    logic                  wdata_unused;

    assign cmd_wr       = host_wr && (host_addr == REG_CMD) && !cmd_en;
    assign data_wr      = host_wr && (host_addr == REG_DATA);
    assign fetch_done   = cmd_en && !cmd_dir && !bad;
    assign wdata_unused = ^{host_wdata[27:12], host_wdata[6:3]};

    qos_cmd_decode #(.NUM_CH(NUM_CH)) u_decode (
        .go        (cmd_en),
        .dir_store (cmd_dir),
        .ch        (cmd_ch),
        .code      (cmd_code),
        .bad       (bad),
        .field_we  (field_we)
    );

    qos_setting_table #(.NUM_CH(NUM_CH)) u_table (
        .clk         (clk),
        .rst_n       (rst_n),
        .soft_clr    (cmd_swrst),
        .sel_ch      (cmd_ch),
        .field_we    (field_we),
        .wdata       (data_q),
        .sel_entry   (sel_entry),
        .peak_flat   (peak_rate_o),
        .xact_flat   (xact_rate_o),
        .burst_flat  (burst_o),
        .qos_flat    (qos_o),
        .sready_flat (sready_o)
    );

    // Command word: capture host commands, retire accesses, track errors
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_en    <= 1'b0;
            cmd_dir   <= 1'b0;
            cmd_swrst <= 1'b0;
            cmd_err   <= 1'b0;
            cmd_ch    <= '0;
            cmd_code  <= '0;
        end else if (cmd_wr) begin
            cmd_en    <= host_wdata[BIT_START] && !host_wdata[BIT_SRST];
            cmd_dir   <= host_wdata[BIT_DIR];
            cmd_swrst <= host_wdata[BIT_SRST];
            cmd_err   <= cmd_err && host_wdata[BIT_ERR];
            cmd_ch    <= host_wdata[CH_LSB +: CH_FIELD_W];
            cmd_code  <= host_wdata[CODE_LSB +: CODE_W];
        end else begin
            if (cmd_swrst) begin
                cmd_swrst <= 1'b0;
            end
            if (cmd_en) begin
                cmd_en <= 1'b0;
                if (bad) begin
                    cmd_err <= 1'b1;
                end
            end
        end
    end

    // Operand word: fetched value takes priority over a host write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q <= '0;
        end else if (fetch_done) begin
            data_q <= pack_field(cmd_code, sel_entry);
        end else if (data_wr) begin
            data_q <= host_wdata;
        end
    end

    // Host read multiplexer
    always_comb begin
        case (host_addr)
            REG_VERSION: host_rdata = VERSION_ID;
            REG_HWCFG:   host_rdata = HWCFG_WORD;
            REG_CMD:     host_rdata = {cmd_en, cmd_dir, cmd_swrst, cmd_err,
                                       16'b0, cmd_ch, 4'b0, cmd_code};
            default:     host_rdata = data_q;
        endcase
    end

endmodule

// File: rtl/qos_cfg_port_chk.sv
// Module: qos_cfg_port_chk
// Temporal checks on the command port, attached to every qos_cfg_port
// instance by the bind at the end of this file.
module qos_cfg_port_chk
    import qos_cfg_pkg::*;
#(
    parameter int NUM_CH = 30
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [1:0]                 host_addr,
    input logic                       host_wr,
    input logic [31:0]                host_wdata,
    input logic                       cmd_en,
    input logic                       cmd_dir,
    input logic                       cmd_swrst,
    input logic                       cmd_err,
    input logic [CH_FIELD_W-1:0]      cmd_ch,
    input logic [CODE_W-1:0]          cmd_code,
    input logic [NUM_CH*RATE_W-1:0]   peak_rate_o,
    input logic [NUM_CH*RATE_W-1:0]   xact_rate_o,
    input logic [NUM_CH*BURST_W-1:0]  burst_o,
    input logic [NUM_CH*QOS_W-1:0]    qos_o,
    input logic [NUM_CH-1:0]          sready_o
);

    logic host_cmd_free;
    logic illegal_go;

    assign host_cmd_free = host_wr && (host_addr == REG_CMD) && !cmd_en;
    assign illegal_go    = cmd_en && ((int'(cmd_ch) >= NUM_CH) ||
                                      (int'(cmd_code) >= NUM_CODES));

    // R2: a start request raises the start flag at the next edge
    p_start_raise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cmd_free && host_wdata[BIT_START] && !host_wdata[BIT_SRST]) |=> cmd_en);

    // R2: an access lasts one cycle
    p_start_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en |=> !cmd_en);

    // R6: an illegal command raises the error flag
    p_bad_sets_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_go |=> cmd_err);

    // R6: an illegal command leaves the table alone
    p_bad_no_change_r6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_go |=> ($stable(peak_rate_o) && $stable(xact_rate_o) &&
                        $stable(burst_o) && $stable(qos_o) && $stable(sready_o)));

    // R7: the error flag holds unless a command write clears it
    p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_err && !(host_cmd_free && !host_wdata[BIT_ERR])) |=> cmd_err);

    // R7: writing 0 to the error bit clears it
    p_err_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (host_cmd_free && !host_wdata[BIT_ERR]) |=> !cmd_err);

    // R8: a soft reset restores all defaults at the next edge
    p_soft_reset_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_swrst |=> (peak_rate_o == '0 && xact_rate_o == '0 && burst_o == '0 &&
                       qos_o == '0 && sready_o == '1));

    // R9: the pending command fields do not move while the access runs
    p_busy_ignore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_en |=> ($stable(cmd_ch) && $stable(cmd_code) && $stable(cmd_dir)));

endmodule

bind qos_cfg_port qos_cfg_port_chk #(.NUM_CH(NUM_CH)) u_qos_cfg_port_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_addr   (host_addr),
    .host_wr     (host_wr),
    .host_wdata  (host_wdata),
    .cmd_en      (cmd_en),
    .cmd_dir     (cmd_dir),
    .cmd_swrst   (cmd_swrst),
    .cmd_err     (cmd_err),
    .cmd_ch      (cmd_ch),
    .cmd_code    (cmd_code),
    .peak_rate_o (peak_rate_o),
    .xact_rate_o (xact_rate_o),
    .burst_o     (burst_o),
    .qos_o       (qos_o),
    .sready_o    (sready_o)
);

// File: tb/qos_cfg_port_bench.sv
// Bench for qos_cfg_port: sweeps every channel index with every code as stores,
// then as fetches, against a model in the bench, then covers the corner cases.
module qos_cfg_port_bench;

    localparam int          CLK_PERIOD = 10;
    localparam int          NCH        = 30;
    localparam logic [31:0] VER        = 32'h0102_0000;
    localparam logic [1:0]  A_VER = 2'd0, A_CFG = 2'd1, A_CMD = 2'd2, A_DAT = 2'd3;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [1:0]          host_addr = 2'd0;
    logic                host_wr = 1'b0;
    logic [31:0]         host_wdata = '0;
    logic [31:0]         host_rdata;
    logic [NCH*12-1:0]   peak_rate_o;
    logic [NCH*12-1:0]   xact_rate_o;
    logic [NCH*8-1:0]    burst_o;
    logic [NCH*4-1:0]    qos_o;
    logic [NCH-1:0]      sready_o;

    int n_checks = 0;
    int n_errors = 0;

    logic [11:0] m_peak  [NCH];
    logic [11:0] m_xact  [NCH];
    logic [7:0]  m_burst [NCH];
    logic [3:0]  m_qos   [NCH];
    logic        m_srdy  [NCH];

    always #(CLK_PERIOD/2) clk = ~clk;

    qos_cfg_port #(.NUM_CH(NCH), .VERSION_ID(VER)) u_qos_cfg_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_addr   (host_addr),
        .host_wr     (host_wr),
        .host_wdata  (host_wdata),
        .host_rdata  (host_rdata),
        .peak_rate_o (peak_rate_o),
        .xact_rate_o (xact_rate_o),
        .burst_o     (burst_o),
        .qos_o       (qos_o),
        .sready_o    (sready_o)
    );

    task automatic check32(input string req, input string what,
                           input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic read_word(input logic [1:0] a, output logic [31:0] v);
        host_addr = a;
        #1;
        v = host_rdata;
    endtask

    // Starts just after a falling edge; the next rising edge captures the write
    task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
        host_addr  = a;
        host_wdata = d;
        host_wr    = 1'b1;
        @(negedge clk);
        host_wr    = 1'b0;
    endtask

    task automatic model_defaults();
        for (int i = 0; i < NCH; i++) begin
            m_peak[i] = '0; m_xact[i] = '0; m_burst[i] = '0;
            m_qos[i] = '0; m_srdy[i] = 1'b1;
        end
    endtask

    task automatic check_table(input string req, input string what);
        int bad_ch;
        bad_ch = -1;
        for (int i = 0; i < NCH; i++) begin
            if (peak_rate_o[i*12 +: 12] !== m_peak[i] || xact_rate_o[i*12 +: 12] !== m_xact[i] ||
                burst_o[i*8 +: 8] !== m_burst[i] || qos_o[i*4 +: 4] !== m_qos[i] ||
                sready_o[i] !== m_srdy[i]) begin
                if (bad_ch < 0) bad_ch = i;
            end
        end
        n_checks++;
        if (bad_ch >= 0) begin
            n_errors++;
            $display("FAIL %s %s: channel %0d actual p%h x%h b%h q%h s%b expected p%h x%h b%h q%h s%b",
                req, what, bad_ch, peak_rate_o[bad_ch*12 +: 12], xact_rate_o[bad_ch*12 +: 12],
                burst_o[bad_ch*8 +: 8], qos_o[bad_ch*4 +: 4], sready_o[bad_ch],
                m_peak[bad_ch], m_xact[bad_ch], m_burst[bad_ch], m_qos[bad_ch], m_srdy[bad_ch]);
        end
    endtask

    function automatic logic [31:0] cmd_word(input logic start, input logic store,
                                              input logic srst, input logic errb,
                                              input int ch, input int code);
        return {start, store, srst, errb, 16'b0, 5'(ch), 4'b0, 3'(code)};
    endfunction

    function automatic logic [31:0] fetch_expect(input int ch, input int code);
        logic [31:0] w;
        w = '0;
        case (code)
            0: w[23:16] = m_burst[ch];
            1: begin w[31:20] = m_peak[ch]; w[15:4] = m_xact[ch]; end
            2: w[3:0] = m_qos[ch];
            3: w[0] = m_srdy[ch];
            default: w = '0;
        endcase
        return w;
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin : main
        logic [31:0] v;
        logic [31:0] d;
        logic        illegal;

        model_defaults();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        read_word(A_CMD, v); check32("R1", "command after reset", v, 32'h0);
        read_word(A_DAT, v); check32("R1", "operand after reset", v, 32'h0);
        check_table("R1", "table after reset");

        // R10: read-only identification words
        read_word(A_VER, v); check32("R10", "version", v, VER);
        read_word(A_CFG, v); check32("R10", "hwcfg", v, {16'b0, 8'd4, 8'(NCH)});
        bus_write(A_VER, 32'hFFFF_FFFF);
        bus_write(A_CFG, 32'h1234_5678);
        read_word(A_VER, v); check32("R10", "version after write", v, VER);
        read_word(A_CFG, v); check32("R10", "hwcfg after write", v, {16'b0, 8'd4, 8'(NCH)});

        // R2: start flag timing on one store
        bus_write(A_DAT, 32'hABC0_0DEF);
        bus_write(A_CMD, cmd_word(1'b1, 1'b1, 1'b0, 1'b0, 4, 1));
        read_word(A_CMD, v); check32("R2", "start flag after capture edge", {31'b0, v[31]}, 32'h1);
        check_table("R2", "table before execution edge");
        @(negedge clk);
        read_word(A_CMD, v); check32("R2", "start flag after execution edge", {31'b0, v[31]}, 32'h0);
        m_peak[4] = 12'hABC; m_xact[4] = 12'h0DE;
        check_table("R3", "rate store on channel 4");

        // R3 R4 R6 R11: store sweep over every index and code
        for (int ch = 0; ch < 32; ch++) begin
            for (int code = 0; code < 8; code++) begin
                d = 32'(((ch * 8) + code + 1) * 32'h9E37_79B9);
                bus_write(A_DAT, d);
                bus_write(A_CMD, cmd_word(1'b1, 1'b1, 1'b0, 1'b0, ch, code));
                @(negedge clk);
                illegal = (ch >= NCH) || (code >= 4);
                if (!illegal) begin
                    case (code)
                        0: m_burst[ch] = d[23:16];
                        1: begin m_peak[ch] = d[31:20]; m_xact[ch] = d[15:4]; end
                        2: m_qos[ch] = d[3:0];
                        default: m_srdy[ch] = d[0];
                    endcase
                end
                check_table(illegal ? "R6" : (code == 1 ? "R3" : "R4"), "store sweep");
                read_word(A_CMD, v);
                check32("R11", "command readback after store", v,
                        cmd_word(1'b0, 1'b1, 1'b0, illegal, ch, code));
                read_word(A_DAT, v);
                check32("R6", "operand unchanged by store", v, d);
            end
        end

        // R5 R6: fetch sweep over every index and code
        for (int ch = 0; ch < 32; ch++) begin
            for (int code = 0; code < 8; code++) begin
                bus_write(A_DAT, 32'hA5A5_5A5A);
                bus_write(A_CMD, cmd_word(1'b1, 1'b0, 1'b0, 1'b0, ch, code));
                @(negedge clk);
                illegal = (ch >= NCH) || (code >= 4);
                read_word(A_DAT, v);
                check32(illegal ? "R6" : "R5", "fetch result", v,
                        illegal ? 32'hA5A5_5A5A : fetch_expect(ch, code));
                read_word(A_CMD, v);
                check32("R6", "error flag after fetch", {31'b0, v[28]}, {31'b0, illegal});
            end
        end
        check_table("R5", "table untouched by fetches");

        // R7: error flag stickiness
        bus_write(A_CMD, cmd_word(1'b1, 1'b1, 1'b0, 1'b0, 31, 2));
        @(negedge clk);
        read_word(A_CMD, v); check32("R7", "error raised", {31'b0, v[28]}, 32'h1);
        bus_write(A_CMD, cmd_word(1'b0, 1'b0, 1'b0, 1'b1, 0, 0));
        @(negedge clk);
        read_word(A_CMD, v); check32("R7", "error kept by writing 1", {31'b0, v[28]}, 32'h1);
        bus_write(A_CMD, cmd_word(1'b0, 1'b0, 1'b0, 1'b0, 0, 0));
        read_word(A_CMD, v); check32("R7", "error cleared by writing 0", {31'b0, v[28]}, 32'h0);

        // R9: back-to-back command writes; the second lands while busy
        bus_write(A_DAT, 32'h0000_0009);
        host_addr  = A_CMD;
        host_wdata = cmd_word(1'b1, 1'b1, 1'b0, 1'b0, 2, 2);
        host_wr    = 1'b1;
        @(negedge clk);
        host_wdata = cmd_word(1'b1, 1'b1, 1'b0, 1'b0, 3, 0);
        @(negedge clk);
        host_wr    = 1'b0;
        m_qos[2] = 4'h9;
        check_table("R9", "only first command applied");
        read_word(A_CMD, v);
        check32("R9", "command fields of first write kept", v,
                cmd_word(1'b0, 1'b1, 1'b0, 1'b0, 2, 2));
        @(negedge clk);
        check_table("R9", "busy write never runs later");

        // R8: soft reset
        bus_write(A_CMD, cmd_word(1'b1, 1'b1, 1'b1, 1'b0, 5, 1));
        read_word(A_CMD, v);
        check32("R8", "soft reset bit visible, no start", {30'b0, v[31], v[29]}, 32'h1);
        check_table("R8", "table before soft reset edge");
        @(negedge clk);
        model_defaults();
        check_table("R8", "defaults after soft reset");
        read_word(A_CMD, v); check32("R8", "soft reset bit self-clears", {31'b0, v[29]}, 32'h0);

        // R1: hardware reset mid-run
        bus_write(A_DAT, 32'hFFFF_0001);
        bus_write(A_CMD, cmd_word(1'b1, 1'b1, 1'b0, 1'b0, 7, 2));
        @(negedge clk);
        m_qos[7] = 4'h1;
        check_table("R4", "qos store before reset");
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        model_defaults();
        check_table("R1", "defaults after reset");
        read_word(A_DAT, v); check32("R1", "operand after reset", v, 32'h0);

        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule